// File: doc/BRIEF.md
# Instruction Fetch Sequencer with Machine Status

This unit is the control front end of a minimal processor core. It keeps the program counter and drives it onto the fetch address port. From instruction memory it takes back an 80-bit little-endian window of ten bytes that starts at that address. Byte 0 of the window sits in bits 7:0.

The unit decodes only the opcode nibble. It supports three operations: step over a one-byte no-op, load an absolute 64-bit jump target, or stop. Selection works as a first-match priority chain that always ends in a default arm. The result is a next-PC value and a one-hot machine status that tells the surrounding environment to keep running, to stop normally, or to stop because of an illegal opcode.

Once the machine stops, the PC and the status freeze until the next reset. The reset input is asynchronous and active-low, and an internal synchronizer releases it on the clock.

Top module: `fetch_seq_unit`

## Requirements
- R1: While reset is asserted, and until its synchronized release, the PC output is 0.
- R2: The opcode is window bits 7:4, the upper nibble of byte 0. The lower nibble of byte 0 has no effect on the next PC or the status.
- R3: Opcode 4'h1 (no-op) drives status 3'b001 (run) in the same cycle, and the PC becomes PC+1 at the next clock edge.
- R4: Opcode 4'h7 (jump) drives status 3'b001, and the PC becomes window bits 71:8 at the next clock edge. Those bits are bytes 1 to 8, read as a little-endian address.
- R5: Opcode 4'h0 (halt) drives status 3'b010 in the same cycle, and the PC does not change at the next edge.
- R6: Any opcode other than 0, 1 and 7 drives status 3'b100 (illegal) in the same cycle, and the PC does not change at the next edge.
- R7: Once status 3'b010 or 3'b100 has been produced, the PC and the status keep their values whatever the window holds, until reset.
- R8: The status output is always exactly one-hot.
- R9: A no-op at PC 2^64-1 wraps the PC to 0.
- R10: A seven-instruction program halts on its seventh instruction with the PC at 0x1e. The program is no-op at 0x00, jumps at 0x01, 0x0a and 0x13, no-ops at 0x1c and 0x1d, and halt at 0x1e.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| instr_win | input | 80 | Ten instruction bytes fetched at pc_o, little-endian |
| pc_o | output | 64 | Current program counter, used as the fetch address |
| status_o | output | 3 | One-hot machine status: 001 run, 010 halted, 100 illegal opcode |

## Verification
The assertions assume that instr_win settles within the same cycle to the bytes stored at pc_o, and that it is stable around the rising edge. This is what a combinational instruction memory provides. They also assume that reset is held for at least the two synchronizer cycles.

The bench keeps to these assumptions. It changes the window only at falling edges and samples half a cycle before the next rising edge. While reset is asserted and the synchronizer drains, it holds a jump-to-zero window so that the PC does not move. The program run builds each window from a byte model addressed by the expected PC, so the window always matches what memory would return.

// File: rtl/fsu_pkg.sv
`timescale 1ns/1ps
package fsu_pkg;
  localparam logic [3:0] OPC_HALT = 4'h0;
  localparam logic [3:0] OPC_NOP  = 4'h1;
  localparam logic [3:0] OPC_JUMP = 4'h7;

  typedef enum logic [2:0] {
    ST_RUN   = 3'b001,
    ST_HALT  = 3'b010,
    ST_BADOP = 3'b100
  } fsu_status_e;
endpackage

// File: rtl/fsu_rst_sync.sv
`timescale 1ns/1ps
module fsu_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/fsu_decode.sv
`timescale 1ns/1ps
module fsu_decode #(
  parameter int WIN_W   = 80,
  parameter int ADDR_W  = 64,
  parameter int OPC_LSB = 4,
  parameter int TGT_LSB = 8
) (
  input  logic [WIN_W-1:0]  win,
  output logic [3:0]        opcode,
  output logic [ADDR_W-1:0] target
);
  localparam int TGT_MSB = TGT_LSB + ADDR_W - 1;

  assign opcode = win[OPC_LSB +: 4];
  assign target = win[TGT_MSB:TGT_LSB];

  // bits outside the opcode and the target are not decoded
  logic unused_bits;
  assign unused_bits = ^{win[OPC_LSB-1:0], win[WIN_W-1:TGT_MSB+1]};
endmodule

// File: rtl/fsu_next_sel.sv
`timescale 1ns/1ps
module fsu_next_sel
  import fsu_pkg::*;
#(
  parameter int              ADDR_W = 64,
  parameter logic [ADDR_W-1:0] FILLER = '1
) (
  input  logic [ADDR_W-1:0] pc,
  input  logic [3:0]        opcode,
  input  logic [ADDR_W-1:0] target,
  output logic [ADDR_W-1:0] nxt_pc,
  output fsu_status_e       dec_status
);
  // first-match priority chain, the last arm is the default
  always_comb begin
    if (opcode == OPC_NOP) begin
      nxt_pc     = pc + ADDR_W'(1);
      dec_status = ST_RUN;
    end else if (opcode == OPC_JUMP) begin
      nxt_pc     = target;
      dec_status = ST_RUN;
    end else if (opcode == OPC_HALT) begin
      nxt_pc     = FILLER;
      dec_status = ST_HALT;
    end else begin
      nxt_pc     = FILLER;
      dec_status = ST_BADOP;
    end
  end
endmodule

// File: rtl/fsu_pc_state.sv
`timescale 1ns/1ps
module fsu_pc_state
  import fsu_pkg::*;
#(
  parameter int ADDR_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] nxt_pc,
  input  fsu_status_e       dec_status,
  output logic [ADDR_W-1:0] pc,
  output logic              stopped,
  output fsu_status_e       status
);
  logic [ADDR_W-1:0] pc_q;
  logic              stop_q, stop_d;
  fsu_status_e       code_q, code_d;
  logic              pc_en, stop_en;

  always_comb begin
    pc_en   = !stop_q && (dec_status == ST_RUN);
    stop_en = !stop_q && (dec_status != ST_RUN);
    stop_d  = 1'b1;
    code_d  = dec_status;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q <= '0;
    end else if (pc_en) begin
      pc_q <= nxt_pc;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stop_q <= 1'b0;
      code_q <= ST_RUN;
    end else if (stop_en) begin
      stop_q <= stop_d;
      code_q <= code_d;
    end
  end

  assign pc      = pc_q;
  assign stopped = stop_q;
  assign status  = stop_q ? code_q : dec_status;

  p_stop_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    stop_q |=> ($stable(pc_q) && $stable(status)));

  p_status_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(status) == 1);
endmodule

// File: rtl/fetch_seq_unit.sv
`timescale 1ns/1ps
module fetch_seq_unit
  import fsu_pkg::*;
#(
  parameter int ADDR_W     = 64,
  parameter int WIN_BYTES  = 10,
  parameter int SYNC_STAGE = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [WIN_BYTES*8-1:0] instr_win,
  output logic [ADDR_W-1:0]      pc_o,
  output logic [2:0]             status_o
);
  localparam int WIN_W = WIN_BYTES * 8;

  logic              rst_n_s;
  logic [3:0]        opcode;
  logic [ADDR_W-1:0] target;
  logic [ADDR_W-1:0] nxt_pc;
  logic [ADDR_W-1:0] pc_cur;
  logic              stopped;
  fsu_status_e       dec_status;
  fsu_status_e       status;

  fsu_rst_sync #(.STAGES(SYNC_STAGE)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_s)
  );

  fsu_decode #(.WIN_W(WIN_W), .ADDR_W(ADDR_W), .OPC_LSB(4), .TGT_LSB(8)) u_dec (
    .win(instr_win), .opcode(opcode), .target(target)
  );

  fsu_next_sel #(.ADDR_W(ADDR_W)) u_sel (
    .pc(pc_cur), .opcode(opcode), .target(target),
    .nxt_pc(nxt_pc), .dec_status(dec_status)
  );

  fsu_pc_state #(.ADDR_W(ADDR_W)) u_state (
    .clk(clk), .rst_n(rst_n_s), .nxt_pc(nxt_pc), .dec_status(dec_status),
    .pc(pc_cur), .stopped(stopped), .status(status)
  );

  assign pc_o     = pc_cur;
  assign status_o = status;

  p_reset_pc_r1: assert property (@(posedge clk)
    !rst_n_s |=> (pc_o == '0));

  p_nop_step_r3: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!stopped && opcode == OPC_NOP) |=> (pc_o == $past(pc_o) + ADDR_W'(1)));

  p_jump_load_r4: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!stopped && opcode == OPC_JUMP) |=> (pc_o == $past(target)));

  p_halt_code_r5: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!stopped && opcode == OPC_HALT) |-> (status_o == 3'b010));

  p_badop_code_r6: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!stopped && opcode != OPC_HALT && opcode != OPC_NOP && opcode != OPC_JUMP)
      |-> (status_o == 3'b100));

  p_stop_freeze_r7: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!stopped && status_o != 3'b001) |=> ($stable(pc_o) && stopped));
endmodule

// File: tb/fetch_seq_unit_bench.sv
`timescale 1ns/1ps
module fetch_seq_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [79:0] instr_win;
  logic [63:0] pc_o;
  logic [2:0]  status_o;

  always #10 clk = ~clk;  // 50 MHz

  fetch_seq_unit u_fetch_seq_unit (
    .clk(clk), .rst_n(rst_n), .instr_win(instr_win),
    .pc_o(pc_o), .status_o(status_o)
  );

  int n_vec = 0;
  int n_bad = 0;
  bit finished = 0;

  // reference state
  logic [63:0] m_pc;
  logic        m_stop;
  logic [2:0]  m_code;

  // scoreboard
  logic [63:0] exp_pc_q[$];
  logic [2:0]  exp_st_q[$];
  string       exp_tag_q[$];
  event        sample_ev;

  logic [7:0] prog [0:47];

  function automatic logic [79:0] fetch_win(logic [63:0] a);
    logic [79:0] w;
    for (int i = 0; i < 10; i++) begin
      logic [63:0] idx;
      idx = a + 64'(i);
      w[8*i +: 8] = (idx < 64'd48) ? prog[idx[5:0]] : 8'h00;
    end
    return w;
  endfunction

  function automatic logic [2:0] exp_status(logic [79:0] w);
    if (m_stop) return m_code;
    case (w[7:4])
      4'h1, 4'h7: return 3'b001;
      4'h0:       return 3'b010;
      default:    return 3'b100;
    endcase
  endfunction

  // monitor: pops expected items and compares
  initial begin
    forever begin
      @(sample_ev);
      while (exp_pc_q.size() > 0) begin
        logic [63:0] ep;
        logic [2:0]  es;
        string       et;
        ep = exp_pc_q.pop_front();
        es = exp_st_q.pop_front();
        et = exp_tag_q.pop_front();
        n_vec++;
        if (pc_o !== ep || status_o !== es) begin
          n_bad++;
          $display("FAIL %s: pc=%h status=%b expected pc=%h status=%b",
                   et, pc_o, status_o, ep, es);
        end
      end
    end
  end

  task automatic push_and_sample(string tag, logic [2:0] es);
    exp_pc_q.push_back(m_pc);
    exp_st_q.push_back(es);
    exp_tag_q.push_back(tag);
    #2;
    -> sample_ev;
    #1;
  endtask

  // driver: apply one window, queue expectation, advance the model
  task automatic apply(logic [79:0] w, string tag);
    @(negedge clk);
    instr_win = w;
    push_and_sample(tag, exp_status(w));
    if (!m_stop) begin
      case (w[7:4])
        4'h1:    m_pc = m_pc + 64'd1;
        4'h7:    m_pc = w[71:8];
        4'h0:    begin m_stop = 1'b1; m_code = 3'b010; end
        default: begin m_stop = 1'b1; m_code = 3'b100; end
      endcase
    end
  endtask

  task automatic check_val(bit ok, string tag, logic [63:0] act, logic [63:0] expv);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, expv);
    end
  endtask

  localparam logic [79:0] JMP0 = 80'h70;

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    instr_win = JMP0;
    m_pc = '0; m_stop = 1'b0; m_code = 3'b001;
    repeat (2) @(negedge clk);
    push_and_sample("R1", 3'b001);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 48; i++) prog[i] = 8'h00;
    prog[8'h00] = 8'h10;
    prog[8'h01] = 8'h70; prog[8'h02] = 8'h13;
    prog[8'h0a] = 8'h70; prog[8'h0b] = 8'h1c;
    prog[8'h13] = 8'h70; prog[8'h14] = 8'h0a;
    prog[8'h1c] = 8'h10;
    prog[8'h1d] = 8'h10;
    prog[8'h1e] = 8'h00;

    rst_n = 1'b0;
    instr_win = JMP0;
    m_pc = '0; m_stop = 1'b0; m_code = 3'b001;
    do_reset();

    apply(80'h10, "R3");                          // no-op at 0
    apply(80'h1F, "R2");                          // low nibble set, still no-op
    apply({8'h00, 64'h0123456789ABCDEF, 8'h7A}, "R2");  // jump, low nibble ignored
    apply({8'h00, 64'hFFFFFFFFFFFFFFFF, 8'h70}, "R4");
    apply(80'h10, "R4");                          // pc now all ones
    apply({8'h00, 64'h0000000000000000, 8'h70}, "R9");  // pc wrapped to 0
    apply(80'h10, "R3");                          // 0 -> 1
    apply({8'h00, 64'h0, 8'h70}, "R4");           // back to 0

    // program run
    begin
      int steps = 0;
      while (!m_stop && steps < 20) begin
        apply(fetch_win(m_pc), "R10");
        steps++;
      end
      check_val(steps == 7, "R10", 64'(steps), 64'd7);
      @(negedge clk); #2;
      check_val(pc_o == 64'h1e, "R10", pc_o, 64'h1e);
    end
    apply(80'h10, "R7");
    apply({8'h00, 64'h5, 8'h70}, "R7");

    do_reset();
    apply(80'hC0, "R6");
    apply(80'h10, "R7");
    apply({8'h00, 64'h9, 8'h70}, "R7");

    do_reset();
    apply(80'h10, "R3");
    apply(80'hF3, "R6");
    apply(80'h10, "R6");

    do_reset();
    apply(80'h00, "R5");
    apply(80'h10, "R5");
    apply(80'h20, "R7");

    repeat (2) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_vec++;
      n_bad++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule